// File: doc/BRIEF.md
# Dual-rail null-spacer hysteresis logic stage

This block is one logic stage of a delay-insensitive datapath that carries every logical bit on a pair of rails and separates successive data words by an all-empty spacer wave. It accepts two multi-bit dual-rail operand words and produces a dual-rail result word. The result is the bitwise AND, the bitwise OR, or the bitwise inversion of the first operand, as chosen by a static operation select. The asynchronous threshold gates are modelled here as a clocked evaluation, which makes the stage synthesizable. Each result bit acts as a hysteresis gate: it takes a new data value only once all of its inputs carry data. It returns to empty only once all of its inputs are empty. For any mixture of the two it keeps its previous value.

Two detectors watch the result word, one for a complete data word and one for a complete empty word. A registered acknowledge follows them and forms a four-phase return-to-zero handshake with the upstream source. The source issues the next wave only after the acknowledge has changed. Because a bit that is still arriving from the previous word holds its gate in data, the acknowledge does not fall, and so a stale bit can never be combined with a new word. A forbidden rail code on any input sets a sticky error flag. For evaluation, such an input counts as empty.

Top module: `dr_hyst_stage`

## Requirements
- R1: Bit i of a word occupies rails [2i+1:2i], with 2'b00 = empty, 2'b01 = TRUE, 2'b10 = FALSE and 2'b11 = forbidden. While rst_n is low at a clock edge, every result pair becomes 2'b00 and ack and code_err become 0. No result pair is ever 2'b11.
- R2: With op_sel = 2'b00 (AND), once both input pairs of a bit carry data, the result pair at the next edge is TRUE if both inputs are TRUE and FALSE otherwise.
- R3: With op_sel = 2'b01 (OR), once both input pairs of a bit carry data, the result pair at the next edge is FALSE if both inputs are FALSE and TRUE otherwise.
- R4: With op_sel[1] = 1 (inversion), the result pair follows only the first operand. At the next edge TRUE becomes FALSE, FALSE becomes TRUE and empty stays empty. The second operand has no effect on the result.
- R5: In a two-input operation, a result bit whose inputs are a mix of data and empty keeps its previous value, so no bit turns to data early.
- R6: A result bit that holds data returns to empty only at the edge after all of its inputs are empty. A slow input that still carries data from the previous word keeps that bit at its data value.
- R7: data_done is 1 exactly when every result pair carries data, and null_done is 1 exactly when every result pair is 2'b00. Both are combinational on the result word.
- R8: ack becomes 1 at the edge after data_done is seen, becomes 0 at the edge after null_done is seen, and otherwise holds its value.
- R9: Any input pair of 2'b11 on either operand sets code_err at the next edge, and code_err stays 1 until reset. That pair is evaluated as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 2 | Operation: 00 AND, 01 OR, 1x inversion of first operand |
| a_rails | input | 2*W | First dual-rail operand word |
| b_rails | input | 2*W | Second dual-rail operand word |
| y_rails | output | 2*W | Dual-rail result word |
| data_done | output | 1 | Every result bit holds data |
| null_done | output | 1 | Every result bit is empty |
| ack | output | 1 | Four-phase handshake acknowledge |
| code_err | output | 1 | Sticky forbidden-input-code flag |

## Verification
The hardest situation to reach is a word in which individual bits arrive and leave at different times. The critical case is a return-to-empty wave in which one slow bit of the second operand still carries the previous word's value. To reach it, the stimulus drives operand bits one at a time in opposite orders on the two operands. It checks the partly evaluated word after every single-bit step. It then holds back one bit during the empty wave and confirms that the result and the acknowledge stay put. Only after that bit is released does it send a new word, chosen so that a stale combination would give a visibly different result.

// File: rtl/dr_stage_pkg.sv
// Shared rail codes, operation encoding and small helpers for the
// dual-rail hysteresis stage. Assumes bit i of a word sits on [2i+1:2i].
package dr_stage_pkg;

    typedef enum logic [1:0] {
        OP_AND     = 2'b00,
        OP_OR      = 2'b01,
        OP_INV     = 2'b10,
        OP_INV_ALT = 2'b11
    } op_e;

    localparam logic [1:0] DR_NULL  = 2'b00;
    localparam logic [1:0] DR_TRUE  = 2'b01;
    localparam logic [1:0] DR_FALSE = 2'b10;
    localparam logic [1:0] DR_BAD   = 2'b11;

    // True when a rail pair carries one of the two data codes.
    function automatic logic dr_is_data(input logic [1:0] pair);
        return (pair == DR_TRUE) || (pair == DR_FALSE);
    endfunction

    // True when the operation uses only the first operand.
    function automatic logic op_is_unary(input logic [1:0] op);
        return op[1];
    endfunction

    // Maps a Boolean value onto its data rail code.
    function automatic logic [1:0] dr_encode(input logic val);
        return val ? DR_TRUE : DR_FALSE;
    endfunction

endpackage

// File: rtl/dr_hyst_gate.sv
// One result bit of the stage: a hysteresis gate modelled as a register.
// It loads the evaluated data code when all used inputs carry data,
// loads empty when all used inputs are empty, and holds otherwise.
// Assumes op is static while any input carries data. A forbidden input
// code counts as not-data, so it reads as empty.
module dr_hyst_gate
    import dr_stage_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] op,
    input  logic [1:0] a_pair,
    input  logic [1:0] b_pair,
    output logic [1:0] y_pair
);

    logic       unary;
    logic       a_dat;
    logic       b_dat;
    logic       all_data;
    logic       all_null;
    logic [1:0] result;

    // Classify the inputs that the selected operation actually uses.
    always_comb begin
        unary    = op_is_unary(op);
        a_dat    = dr_is_data(a_pair);
        b_dat    = dr_is_data(b_pair);
        all_data = a_dat && (unary || b_dat);
        all_null = !a_dat && (unary || !b_dat);
    end

    // Data-wave truth table for the selected operation.
    always_comb begin
        case (op)
            OP_AND:  result = dr_encode((a_pair == DR_TRUE) && (b_pair == DR_TRUE));
            OP_OR:   result = dr_encode(!((a_pair == DR_FALSE) && (b_pair == DR_FALSE)));
            default: result = dr_encode(a_pair == DR_FALSE);
        endcase
    end

    // Hysteresis state: change only on complete data or complete empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_pair <= DR_NULL;
        end else if (all_data) begin
            y_pair <= result;
        end else if (all_null) begin
            y_pair <= DR_NULL;
        end
    end

endmodule

// File: rtl/dr_word_detect.sv
// Word-level completion detectors on a dual-rail word: one flags that all
// bits carry data, the other that all bits are empty. Purely combinational.
module dr_word_detect
    import dr_stage_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [2*W-1:0] word,
    output logic           data_all,
    output logic           null_all
);

    logic [W-1:0] data_bits;
    logic [W-1:0] null_bits;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit classification of the result pair.
        assign data_bits[i] = dr_is_data(word[2*i +: 2]);
        assign null_bits[i] = (word[2*i +: 2] == DR_NULL);
    end

    // Reduce the per-bit flags into the two word-level completions.
    assign data_all = &data_bits;
    assign null_all = &null_bits;

endmodule

// File: rtl/dr_ack_ctrl.sv
// Four-phase acknowledge: set after a complete data word has been seen,
// cleared after a complete empty word, held in between. Assumes the two
// completion inputs are never both high.
module dr_ack_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic data_all,
    input  logic null_all,
    output logic ack
);

    // Track the handshake phase from the completion detectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
        end else if (data_all) begin
            ack <= 1'b1;
        end else if (null_all) begin
            ack <= 1'b0;
        end
    end

endmodule

// File: rtl/dr_code_monitor.sv
// Watches every input pair of both operands for the forbidden code and
// keeps a sticky flag once one has been seen. Cleared only by reset.
module dr_code_monitor
    import dr_stage_pkg::*;
#(
    parameter int W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*W-1:0] a_rails,
    input  logic [2*W-1:0] b_rails,
    output logic           code_err
);

    logic bad_now;

    // Detect any forbidden pair on either operand this cycle.
    always_comb begin
        bad_now = 1'b0;
        for (int i = 0; i < W; i++) begin
            bad_now = bad_now | (a_rails[2*i +: 2] == DR_BAD)
                              | (b_rails[2*i +: 2] == DR_BAD);
        end
    end

    // Sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_err <= 1'b0;
        end else if (bad_now) begin
            code_err <= 1'b1;
        end
    end

endmodule

// File: rtl/dr_hyst_stage.sv
// Top of the dual-rail hysteresis logic stage. W result gates evaluate
// bitwise AND, OR or inversion; word detectors and a registered
// acknowledge close the four-phase loop; a monitor flags forbidden codes.
// Assumes op_sel changes only while all inputs are empty.
module dr_hyst_stage
    import dr_stage_pkg::*;
#(
    parameter int W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     op_sel,
    input  logic [2*W-1:0] a_rails,
    input  logic [2*W-1:0] b_rails,
    output logic [2*W-1:0] y_rails,
    output logic           data_done,
    output logic           null_done,
    output logic           ack,
    output logic           code_err
);

    // One hysteresis gate per logical bit.
    for (genvar i = 0; i < W; i++) begin : g_gate
        dr_hyst_gate u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .op     (op_sel),
            .a_pair (a_rails[2*i +: 2]),
            .b_pair (b_rails[2*i +: 2]),
            .y_pair (y_rails[2*i +: 2])
        );
    end

    // Completion detection on the result word.
    dr_word_detect #(.W(W)) u_detect (
        .word     (y_rails),
        .data_all (data_done),
        .null_all (null_done)
    );

    // Handshake acknowledge toward the source.
    dr_ack_ctrl u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_all (data_done),
        .null_all (null_done),
        .ack      (ack)
    );

    // Forbidden-code monitor on the operands.
    dr_code_monitor #(.W(W)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_rails  (a_rails),
        .b_rails  (b_rails),
        .code_err (code_err)
    );

endmodule

// File: rtl/dr_hyst_stage_chk.sv
// Property checker for dr_hyst_stage, attached by bind. It observes ports
// only and relates inputs of one cycle to outputs of the next.
module dr_hyst_stage_chk
    import dr_stage_pkg::*;
#(
    parameter int W = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     op_sel,
    input logic [2*W-1:0] a_rails,
    input logic [2*W-1:0] b_rails,
    input logic [2*W-1:0] y_rails,
    input logic           data_done,
    input logic           null_done,
    input logic           ack,
    input logic           code_err
);

    logic [W-1:0] in_mixed;
    logic         in_all_null;
    logic         in_bad;

    // Input-side observations used by the properties.
    always_comb begin
        in_all_null = 1'b1;
        in_bad      = 1'b0;
        for (int i = 0; i < W; i++) begin
            in_mixed[i] = !op_sel[1] &&
                          (dr_is_data(a_rails[2*i +: 2]) != dr_is_data(b_rails[2*i +: 2]));
            in_all_null = in_all_null && !dr_is_data(a_rails[2*i +: 2]) &&
                          (op_sel[1] || !dr_is_data(b_rails[2*i +: 2]));
            in_bad      = in_bad || (a_rails[2*i +: 2] == DR_BAD) ||
                          (b_rails[2*i +: 2] == DR_BAD);
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        p_rail_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
            y_rails[2*i +: 2] != DR_BAD);

        p_hold_mixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_mixed[i])) |-> $stable(y_rails[2*i +: 2]));
    end

    p_null_complete_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_all_null)) |-> null_done);

    p_detect_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_done && null_done));

    p_ack_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(data_done));

    p_ack_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> $past(null_done));

    p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_bad)) |-> code_err);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> code_err);

endmodule

bind dr_hyst_stage dr_hyst_stage_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_sel    (op_sel),
    .a_rails   (a_rails),
    .b_rails   (b_rails),
    .y_rails   (y_rails),
    .data_done (data_done),
    .null_done (null_done),
    .ack       (ack),
    .code_err  (code_err)
);

// File: tb/dr_hyst_stage_tb.sv
// Self-checking bench: exhaustive sweep of all data words for W=4 in every
// operation, plus skewed single-bit arrival, a slow bit, and bad codes.
module dr_hyst_stage_tb;

    localparam int W = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     op_sel = 2'b00;
    logic [2*W-1:0] a_rails = '0;
    logic [2*W-1:0] b_rails = '0;
    logic [2*W-1:0] y_rails;
    logic           data_done;
    logic           null_done;
    logic           ack;
    logic           code_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    dr_hyst_stage #(.W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_sel    (op_sel),
        .a_rails   (a_rails),
        .b_rails   (b_rails),
        .y_rails   (y_rails),
        .data_done (data_done),
        .null_done (null_done),
        .ack       (ack),
        .code_err  (code_err)
    );

    // Encode a Boolean word: 1 -> 2'b01 (TRUE), 0 -> 2'b10 (FALSE).
    function automatic logic [2*W-1:0] enc(input logic [W-1:0] v);
        logic [2*W-1:0] r;
        for (int i = 0; i < W; i++) r[2*i +: 2] = v[i] ? 2'b01 : 2'b10;
        return r;
    endfunction

    // Keep pairs of a rail word only where mask is set, empty elsewhere.
    function automatic logic [2*W-1:0] keep(input logic [2*W-1:0] w, input logic [W-1:0] m);
        logic [2*W-1:0] r;
        for (int i = 0; i < W; i++) r[2*i +: 2] = m[i] ? w[2*i +: 2] : 2'b00;
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        a_rails = '0;
        b_rails = '0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [2*W-1:0] res;
        logic [W-1:0]   av;
        logic [W-1:0]   bv;
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk("R1 reset y", y_rails, '0);
        chk("R1 reset ack", ack, 0);
        chk("R1 reset err", code_err, 0);
        chk("R7 reset null_done", null_done, 1);
        chk("R7 reset data_done", data_done, 0);

        // R9: forbidden code on a bit0, rest TRUE
        op_sel  = 2'b00;
        a_rails = 8'b01_01_01_11;
        b_rails = 8'b01_01_01_01;
        tick();
        chk("R9 bad pair read as empty", y_rails, 8'b01_01_01_00);
        chk("R9 err set", code_err, 1);
        a_rails = '0;
        b_rails = '0;
        tick();
        chk("R9 return to empty", y_rails, '0);
        chk("R9 err sticky", code_err, 1);
        rst_n = 1'b0;
        tick();
        chk("R1 err cleared by reset", code_err, 0);
        rst_n = 1'b1;
        tick();

        // R2 R3: exhaustive two-input sweep with skewed operand arrival
        for (int m = 0; m < 2; m++) begin
            op_sel = 2'(m);
            for (int x = 0; x < 16; x++) begin
                for (int z = 0; z < 16; z++) begin
                    av  = 4'(x);
                    bv  = 4'(z);
                    res = (m == 0) ? enc(av & bv) : enc(av | bv);
                    a_rails = enc(av);
                    tick();
                    chk("R5 first operand alone", y_rails, '0);
                    chk("R7 not data_done early", data_done, 0);
                    b_rails = enc(bv);
                    tick();
                    chk((m == 0) ? "R2 AND result" : "R3 OR result", y_rails, res);
                    chk("R7 data_done", data_done, 1);
                    chk("R8 ack one edge late", ack, 0);
                    tick();
                    chk("R8 ack rises", ack, 1);
                    a_rails = '0;
                    tick();
                    chk("R6 hold on partial empty", y_rails, res);
                    chk("R7 not null_done early", null_done, 0);
                    b_rails = '0;
                    tick();
                    chk("R6 empty when all empty", y_rails, '0);
                    chk("R8 ack held", ack, 1);
                    tick();
                    chk("R8 ack falls", ack, 0);
                end
            end
        end

        // R4: inversion ignores second operand
        for (int m = 2; m < 4; m++) begin
            op_sel = 2'(m);
            for (int x = 0; x < 16; x++) begin
                for (int z = 0; z < 16; z++) begin
                    av  = 4'(x);
                    bv  = 4'(z);
                    res = enc(~av);
                    a_rails = enc(av);
                    tick();
                    chk("R4 inversion result", y_rails, res);
                    b_rails = enc(bv);
                    tick();
                    chk("R4 second operand no effect", y_rails, res);
                    chk("R8 ack rises", ack, 1);
                    a_rails = '0;
                    tick();
                    chk("R4 empty passes through", y_rails, '0);
                    b_rails = '0;
                    tick();
                    chk("R8 ack falls", ack, 0);
                end
            end
        end

        // R5 R6: bit-by-bit skew, AND, a in rising order, b in falling order
        op_sel = 2'b00;
        av  = 4'b1011;
        bv  = 4'b1101;
        res = enc(av & bv);
        for (int k = 0; k < W; k++) begin
            a_rails[2*k +: 2] = enc(av)[2*k +: 2];
            tick();
            chk("R5 skewed first operand holds empty", y_rails, '0);
        end
        for (int k = W - 1; k >= 0; k--) begin
            logic [W-1:0] mk;
            mk = '0;
            for (int j = k; j < W; j++) mk[j] = 1'b1;
            b_rails[2*k +: 2] = enc(bv)[2*k +: 2];
            tick();
            chk("R5 only completed bits evaluate", y_rails, keep(res, mk));
        end
        tick();
        chk("R8 ack after skewed word", ack, 1);
        for (int k = 0; k < W; k++) begin
            a_rails[2*k +: 2] = 2'b00;
            tick();
            chk("R6 skewed empty wave holds data", y_rails, res);
        end
        // slow bit 0 of b keeps the previous word's value
        for (int k = W - 1; k >= 1; k--) begin
            logic [W-1:0] mk;
            mk = '0;
            for (int j = 0; j < k; j++) mk[j] = 1'b1;
            b_rails[2*k +: 2] = 2'b00;
            tick();
            chk("R6 completed bits return to empty", y_rails, keep(res, mk));
        end
        tick();
        chk("R6 slow bit holds its gate", y_rails, keep(res, 4'b0001));
        chk("R7 no null_done with slow bit", null_done, 0);
        chk("R8 ack held with slow bit", ack, 1);
        b_rails[1:0] = 2'b00;
        tick();
        chk("R6 slow bit released", y_rails, '0);
        tick();
        chk("R8 ack falls after slow bit", ack, 0);
        // new word: a stale b0 (TRUE) would give bit0 TRUE; correct is FALSE
        a_rails = enc(4'b0111);
        b_rails = enc(4'b0010);
        tick();
        chk("R6 new word not mixed with stale bit", y_rails, enc(4'b0010));

        finish_run();
    end

endmodule